// File: doc/BRIEF.md
# Incremental PID Duty Compensator

This block turns each sampled output-voltage reading into a duty command for a switching regulator. It forms the error as the reference minus the sample, then runs a discrete PID in velocity form, whose integrator pole sits at z = 1: the new duty equals the previous duty plus three weighted errors, drawn from the current sample and the two samples before it. The three weights are signed fixed-point parameters. Their fraction width is also a parameter.

A small sequencer spreads the arithmetic over clock cycles. A sample presented with its strobe in one cycle yields a duty word, with a one-cycle valid pulse, three cycles later. The block accepts no new sample while a computation is running. The result is clamped to the duty range. The stored previous duty is the clamped value, so a long stretch of saturation does not wind the integrator up.

Top module: `pid_comp`

## Requirements
- R1: While reset is asserted, and after it is released, `duty` is 0 and `duty_vld` is 0. The two stored past errors are 0.
- R2: The error is the signed difference `vref - smp`, with both inputs read as unsigned, so 600 and 500 give +100.
- R3: A sample is accepted when `smp_vld` is high in a cycle where the block is idle. `duty_vld` is then high for exactly one cycle, which is the third cycle after the accepting cycle.
- R4: The new duty is u(n) = floor((u(n-1)·2^FRAC_W + B0·e(n) + B1·e(n-1) + B2·e(n-2)) / 2^FRAC_W), clamped as R5 and R6 state. B0, B1 and B2 carry FRAC_W fraction bits. With the defaults (640, -1024, 416; FRAC_W = 8), a first error of +100 after reset gives 250.
- R5: A result above 2^DUTY_W - 1 is clamped to 2^DUTY_W - 1, which is 4095 with the defaults.
- R6: A result below 0 is clamped to 0.
- R7: The u(n-1) used by the next update is the clamped duty. After long saturation at 4095 with error +1023, a zero error gives 1665.
- R8: After each update the history shifts: e(n-1) takes e(n) and e(n-2) takes e(n-1).
- R9: A strobe that arrives during the two cycles after an acceptance is ignored. It produces no extra `duty_vld`, and its data does not affect the result.
- R10: `duty` holds its value in every cycle in which `duty_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | New voltage sample strobe |
| smp | input | SAMPLE_W (10) | Sampled output voltage, unsigned |
| vref | input | SAMPLE_W (10) | Voltage reference, unsigned |
| duty | output | DUTY_W (12) | Duty command, unsigned |
| duty_vld | output | 1 | One-cycle pulse when `duty` updates |

## Verification
The hardest conditions to reach from the ports are anti-windup recovery and the two clamps. Each needs dozens of consecutive samples with a full-scale error of one sign, because the net integral gain is small. The bench therefore drives long runs of maximum positive error and then maximum negative error. Between them it sends a single zero-error sample, which exposes the stored clamped value. Rejection of a strobe during the busy window is forced by holding the strobe high, with conflicting data, through the two cycles after an acceptance.

// File: rtl/pid_pkg.sv
package pid_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_FIN  = 2'd2
  } pid_st_e;
endpackage

// File: rtl/pid_ctrl.sv
module pid_ctrl
  import pid_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_vld,
  output logic accept,
  output logic mac_en,
  output logic fin,
  output logic busy
);
  pid_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (smp_vld) st_d = ST_MAC;
      ST_MAC:  st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign accept = (st_q == ST_IDLE) && smp_vld;
  assign mac_en = (st_q == ST_MAC);
  assign fin    = (st_q == ST_FIN);
  assign busy   = (st_q != ST_IDLE);
endmodule

// File: rtl/pid_err_hist.sv
module pid_err_hist #(
  parameter int SAMPLE_W = 10,
  localparam int E_W = SAMPLE_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  logic                       shift,
  input  logic [SAMPLE_W-1:0]        smp,
  input  logic [SAMPLE_W-1:0]        vref,
  output logic signed [E_W-1:0]      e0,
  output logic signed [E_W-1:0]      e1,
  output logic signed [E_W-1:0]      e2
);
  logic signed [E_W-1:0] err_now;
  logic signed [E_W-1:0] e0_d, e1_d, e2_d;

  assign err_now = $signed({1'b0, vref}) - $signed({1'b0, smp});

  always_comb begin
    e0_d = e0;
    e1_d = e1;
    e2_d = e2;
    if (accept) e0_d = err_now;
    if (shift) begin
      e1_d = e0;
      e2_d = e1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e0 <= '0;
      e1 <= '0;
      e2 <= '0;
    end else begin
      e0 <= e0_d;
      e1 <= e1_d;
      e2 <= e2_d;
    end
  end
endmodule

// File: rtl/pid_mac.sv
module pid_mac #(
  parameter int DUTY_W = 12,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 8,
  parameter int E_W    = 11,
  parameter int ACC_W  = 32,
  parameter logic signed [COEF_W-1:0] B0 = 16'sd640,
  parameter logic signed [COEF_W-1:0] B1 = -16'sd1024,
  parameter logic signed [COEF_W-1:0] B2 = 16'sd416
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mac_en,
  input  logic [DUTY_W-1:0]        u_prev,
  input  logic signed [E_W-1:0]    e0,
  input  logic signed [E_W-1:0]    e1,
  input  logic signed [E_W-1:0]    e2,
  output logic signed [ACC_W-1:0]  acc_sum
);
  localparam logic signed [ACC_W-1:0] K0 = ACC_W'(B0);
  localparam logic signed [ACC_W-1:0] K1 = ACC_W'(B1);
  localparam logic signed [ACC_W-1:0] K2 = ACC_W'(B2);

  logic signed [ACC_W-1:0] base, x0, x1, x2, part_d, part_q;

  assign base = ACC_W'($signed({1'b0, u_prev})) <<< FRAC_W;
  assign x0   = ACC_W'(e0);
  assign x1   = ACC_W'(e1);
  assign x2   = ACC_W'(e2);

  // first cycle: previous output plus the two newest error terms
  assign part_d = base + K0 * x0 + K1 * x1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      part_q <= '0;
    else if (mac_en) part_q <= part_d;
  end

  // second cycle: oldest error term closes the sum
  assign acc_sum = part_q + K2 * x2;
endmodule

// File: rtl/pid_sat.sv
module pid_sat #(
  parameter int DUTY_W = 12,
  parameter int FRAC_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic signed [ACC_W-1:0] acc_sum,
  output logic [DUTY_W-1:0]       duty_sat
);
  localparam int unsigned DUTY_MAX = (1 << DUTY_W) - 1;
  localparam logic signed [ACC_W-1:0] MAX_S = $signed(ACC_W'(DUTY_MAX));

  logic signed [ACC_W-1:0] whole;

  assign whole = acc_sum >>> FRAC_W;

  always_comb begin
    if (whole < 0)          duty_sat = '0;
    else if (whole > MAX_S) duty_sat = DUTY_W'(DUTY_MAX);
    else                    duty_sat = whole[DUTY_W-1:0];
  end
endmodule

// File: rtl/pid_comp.sv
module pid_comp #(
  parameter int SAMPLE_W = 10,
  parameter int DUTY_W   = 12,
  parameter int COEF_W   = 16,
  parameter int FRAC_W   = 8,
  parameter int GUARD_W  = 3,
  parameter logic signed [COEF_W-1:0] B0 = 16'sd640,
  parameter logic signed [COEF_W-1:0] B1 = -16'sd1024,
  parameter logic signed [COEF_W-1:0] B2 = 16'sd416
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic [SAMPLE_W-1:0] vref,
  output logic [DUTY_W-1:0]   duty,
  output logic                duty_vld
);
  localparam int E_W    = SAMPLE_W + 1;
  localparam int PROD_W = COEF_W + E_W;
  localparam int BASE_W = DUTY_W + FRAC_W + 1;
  localparam int ACC_W  = ((PROD_W > BASE_W) ? PROD_W : BASE_W) + GUARD_W;

  logic accept, mac_en, fin, busy;
  logic signed [E_W-1:0]   err0, err1, err2;
  logic signed [ACC_W-1:0] acc_sum;
  logic [DUTY_W-1:0]       duty_sat, duty_d;
  logic                    vld_d;

  pid_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .accept(accept), .mac_en(mac_en), .fin(fin), .busy(busy)
  );

  pid_err_hist #(.SAMPLE_W(SAMPLE_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .accept(accept), .shift(fin),
    .smp(smp), .vref(vref), .e0(err0), .e1(err1), .e2(err2)
  );

  pid_mac #(
    .DUTY_W(DUTY_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .E_W(E_W),
    .ACC_W(ACC_W), .B0(B0), .B1(B1), .B2(B2)
  ) u_mac (
    .clk(clk), .rst_n(rst_n), .mac_en(mac_en), .u_prev(duty),
    .e0(err0), .e1(err1), .e2(err2), .acc_sum(acc_sum)
  );

  pid_sat #(.DUTY_W(DUTY_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_sat (
    .acc_sum(acc_sum), .duty_sat(duty_sat)
  );

  // the output register doubles as the clamped u(n-1)
  always_comb begin
    duty_d = duty;
    vld_d  = 1'b0;
    if (fin) begin
      duty_d = duty_sat;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty     <= '0;
      duty_vld <= 1'b0;
    end else begin
      duty     <= duty_d;
      duty_vld <= vld_d;
    end
  end
endmodule

// File: rtl/pid_comp_chk.sv
module pid_comp_chk #(
  parameter int DUTY_W = 12,
  parameter int E_W    = 11
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   smp_vld,
  input logic                   busy,
  input logic                   duty_vld,
  input logic [DUTY_W-1:0]      duty,
  input logic signed [E_W-1:0]  e0,
  input logic signed [E_W-1:0]  e1,
  input logic signed [E_W-1:0]  e2
);
  a_r3_lat_three: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !busy) |-> ##3 duty_vld);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    duty_vld |=> !duty_vld);

  a_r9_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 !busy);

  a_r9_vld_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    duty_vld |-> ($past(busy) && $past(busy, 2)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_vld |-> $stable(duty));

  a_r8_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    duty_vld |-> (e1 == $past(e0) && e2 == $past(e1)));
endmodule

bind pid_comp pid_comp_chk #(.DUTY_W(DUTY_W), .E_W(E_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .busy(busy),
  .duty_vld(duty_vld), .duty(duty), .e0(err0), .e1(err1), .e2(err2)
);

// File: tb/pid_comp_bench.sv
module pid_comp_bench;
  localparam int SW = 10;
  localparam int DW = 12;
  localparam int FW = 8;
  localparam int C0 = 640, C1 = -1024, C2 = 416;
  localparam int DMAX = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic [SW-1:0] smp = '0;
  logic [SW-1:0] vref = '0;
  logic [DW-1:0] duty;
  logic duty_vld;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string tag = "R1";

  // behavioural reference state
  int m_u = 0, m_e1 = 0, m_e2 = 0, m_pend = 0, m_cnt = 0;
  int exp_duty = 0;
  bit exp_vld = 1'b0;

  always #10 clk = ~clk;

  pid_comp u_pid_comp (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp), .vref(vref),
    .duty(duty), .duty_vld(duty_vld)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_u = 0; m_e1 = 0; m_e2 = 0; m_pend = 0; m_cnt = 0;
      exp_duty = 0; exp_vld = 1'b0;
    end else begin
      exp_vld = 1'b0;
      if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          int s;
          s = m_u * (1 << FW) + C0 * m_pend + C1 * m_e1 + C2 * m_e2;
          s = s >>> FW;
          if (s < 0) s = 0;
          if (s > DMAX) s = DMAX;
          m_u = s;
          m_e2 = m_e1;
          m_e1 = m_pend;
          exp_duty = s;
          exp_vld = 1'b1;
        end
      end else if (smp_vld) begin
        m_pend = int'(vref) - int'(smp);
        m_cnt = 2;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(duty_vld == exp_vld, "R3", int'(duty_vld), int'(exp_vld));
      chk(int'(duty) == exp_duty, tag, int'(duty), exp_duty);
    end
  end

  task automatic send(input int r, input int s);
    vref = SW'(r); smp = SW'(s); smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    smp_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk(duty == '0, "R1", int'(duty), 0);
    chk(duty_vld == 1'b0, "R1", int'(duty_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    tag = "R1";
    do_reset();

    tag = "R2";
    send(600, 500);
    chk(duty == 12'd250, "R2", int'(duty), 250);

    tag = "R4";
    for (int i = 0; i < 12; i++) begin
      send(512, 480 + (i * 37) % 70);
      chk(int'(duty) == exp_duty, "R4", int'(duty), exp_duty);
    end
    send(100, 140);
    send(900, 870);

    tag = "R5";
    for (int i = 0; i < 45; i++) send(1023, 0);
    chk(int'(duty) == DMAX, "R5", int'(duty), DMAX);

    tag = "R7";
    send(300, 300);
    chk(duty == 12'd1665, "R7", int'(duty), 1665);

    tag = "R6";
    for (int i = 0; i < 45; i++) send(0, 1023);
    chk(duty == '0, "R6", int'(duty), 0);

    tag = "R9";
    begin
      int pulses = 0;
      vref = 10'd700; smp = 10'd600; smp_vld = 1'b1;
      @(negedge clk);
      vref = 10'd0; smp = 10'd1023;
      @(negedge clk);
      pulses += int'(duty_vld);
      @(negedge clk);
      pulses += int'(duty_vld);
      smp_vld = 1'b0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        pulses += int'(duty_vld);
      end
      chk(pulses == 1, "R9", pulses, 1);
      chk(int'(duty) == exp_duty, "R9", int'(duty), exp_duty);
    end

    tag = "R10";
    begin
      logic [DW-1:0] held;
      held = duty;
      vref = 10'd1023; smp = 10'd0;
      repeat (10) @(negedge clk);
      chk(duty == held, "R10", int'(duty), int'(held));
    end

    tag = "R8";
    send(400, 380);
    send(380, 400);
    chk(int'(duty) == exp_duty, "R8", int'(duty), exp_duty);
    do_reset();
    send(600, 500);
    chk(duty == 12'd250, "R8", int'(duty), 250);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule